// File: doc/BRIEF.md
# Constant Buffer Upload Controller

This block handles inline uploads of shader constants in a graphics front end, and it records how each shader stage binds constant buffers. A command stream writes registers through one valid/ready write port. Four configuration registers hold the buffer base address as two 32-bit words, the buffer size in bytes and the current byte position. Sixteen aliased data-port indices all behave the same way. Each accepted data-port write becomes one 32-bit memory write request at base plus position, and the position then moves on by one word. A write that would land outside the buffer, or into a buffer whose base is zero, is dropped and raises an error pulse.

Five bind registers, one for each shader stage, capture a snapshot of the current base and size into a per-stage table of slots. A separate setup strobe performs a fixed preset in one step. It programs a default size, loads a base taken from a parameter word shifted left by eight, and binds slot 1 of the chosen stage. The memory write port follows valid/ready rules. A request holds its address and data until it is taken. While a request is pending, the write port and the setup strobe are stalled and `busy` stays high. The bind table can be read at any time through a combinational lookup port.

Top module: `cbu_upload_ctrl`

## Requirements
- R1: After reset, `mem_valid`, `busy`, `err_null` and `err_bound` are 0 and `wr_ready` is 1. Every table slot reads back as disabled, with index, address and size all zero. The base, size and position registers are zero.
- R2: A write accepted at any index from 0x10 to 0x1F (the data ports) raises `mem_valid` in the next cycle. `mem_addr` equals {index 0x00 value, index 0x01 value} plus the position, and `mem_data` equals the written word.
- R3: Each data-port write that issues a request advances the position by 4, so back-to-back requests land on consecutive words.
- R4: When the 64-bit base is zero, a data-port write issues no request, leaves the position unchanged and pulses `err_null` for one cycle. This check takes precedence over R5.
- R5: When position + 4 is greater than the size register (index 0x02), a data-port write issues no request, leaves the position unchanged and pulses `err_bound` for one cycle. Position + 4 equal to the size is accepted.
- R6: Once raised, `mem_valid`, `mem_addr` and `mem_data` stay unchanged until a cycle in which `mem_ready` is 1. `mem_valid` falls in the following cycle. While `mem_valid` is 1, `busy` is 1 and `wr_ready` is 0.
- R7: The position register (index 0x03) can be written directly. Bind writes and the setup preset do not change it.
- R8: Indices 0x20 to 0x24 are the bind registers for the stages, in this order: vertex, tessellation control, tessellation evaluation, geometry, fragment. A write stores {enabled = bit 0, index = bits 8:4, current base, current size} into that stage's slot numbered bits 8:4. A slot number of 18 or more is ignored.
- R9: A setup strobe with a stage below 5 sets the size to 0x10000 and the base to the parameter shifted left by 8 (zero-extended to 64 bits). It also fills slot 1 of that stage with {enabled 1, index 1, new base, 0x10000}. A stage of 5 or more changes nothing. While the strobe is high, `wr_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write offered |
| wr_ready | output | 1 | Register write can be taken this cycle |
| wr_idx | input | 8 | Register index |
| wr_data | input | 32 | Register write value |
| setup_stb | input | 1 | Request the fixed shader-setup preset |
| setup_stage | input | 3 | Stage for the preset |
| setup_param | input | 32 | Base address parameter, shifted left by 8 |
| mem_valid | output | 1 | Memory write request pending |
| mem_ready | input | 1 | Memory side takes the request |
| mem_addr | output | 64 | Byte address of the request |
| mem_data | output | 32 | Word to store |
| busy | output | 1 | A request is outstanding; writes are stalled |
| err_null | output | 1 | One-cycle pulse: data write dropped because the base is zero |
| err_bound | output | 1 | One-cycle pulse: data write dropped because it falls past the buffer end |
| rd_stage | input | 3 | Table lookup stage |
| rd_slot | input | 5 | Table lookup slot |
| rd_en | output | 1 | Looked-up slot enabled bit |
| rd_index | output | 5 | Looked-up slot index |
| rd_addr | output | 64 | Looked-up slot base address |
| rd_size | output | 32 | Looked-up slot size |

## Verification
A data-port write accepted at a clock edge shows its result in the cycle that follows. That result is either the request on `mem_valid`/`mem_addr`/`mem_data` or an error pulse, so the bench samples at the falling edge right after the accepting edge. Bind and setup effects are in the table one edge after acceptance and are read through the combinational lookup port, which is settled a moment after the inputs are set. After `mem_ready` is driven, the drop of `mem_valid` is checked one edge later. During the random wait before that, the bench checks that the request stays held and that `wr_ready` stays low.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SLOT_W = 5;
  localparam int unsigned STG_W  = 3;
  localparam int unsigned NUM_STAGES = 5;

  typedef enum logic [STG_W-1:0] {
    STG_VERTEX    = 3'd0,
    STG_TESS_CTRL = 3'd1,
    STG_TESS_EVAL = 3'd2,
    STG_GEOMETRY  = 3'd3,
    STG_FRAGMENT  = 3'd4
  } stage_e;

  typedef struct packed {
    logic              en;
    logic [SLOT_W-1:0] idx;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] size;
  } bind_rec_t;
endpackage

// File: rtl/cbu_cfg_regs.sv
module cbu_cfg_regs
  import cbu_pkg::*;
#(
  parameter int unsigned        IDX_W       = 8,
  parameter logic [IDX_W-1:0]   REG_ADDR_HI = 8'h00,
  parameter logic [IDX_W-1:0]   REG_ADDR_LO = 8'h01,
  parameter logic [IDX_W-1:0]   REG_SIZE    = 8'h02,
  parameter logic [IDX_W-1:0]   REG_POS     = 8'h03,
  parameter logic [DATA_W-1:0]  SETUP_SIZE  = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pos_adv,
  input  logic              setup_fire,
  input  logic [ADDR_W-1:0] setup_addr,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_size,
  output logic [DATA_W-1:0] buf_pos
);
  localparam logic [DATA_W-1:0] WORD_BYTES = DATA_W'(DATA_W / 8);

  logic [DATA_W-1:0] hi_q, lo_q, size_q, pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      size_q <= '0;
      pos_q  <= '0;
    end else begin
      if (setup_fire) begin
        hi_q   <= setup_addr[ADDR_W-1:DATA_W];
        lo_q   <= setup_addr[DATA_W-1:0];
        size_q <= SETUP_SIZE;
      end else if (wr_fire) begin
        if (wr_idx == REG_ADDR_HI) hi_q   <= wr_data;
        if (wr_idx == REG_ADDR_LO) lo_q   <= wr_data;
        if (wr_idx == REG_SIZE)    size_q <= wr_data;
      end
      if (wr_fire && wr_idx == REG_POS) pos_q <= wr_data;
      else if (pos_adv)                 pos_q <= pos_q + WORD_BYTES;
    end
  end

  assign buf_addr = {hi_q, lo_q};
  assign buf_size = size_q;
  assign buf_pos  = pos_q;
endmodule

// File: rtl/cbu_data_path.sv
module cbu_data_path
  import cbu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_fire,
  input  logic [DATA_W-1:0] data_val,
  input  logic [ADDR_W-1:0] buf_addr,
  input  logic [DATA_W-1:0] buf_pos,
  input  logic [DATA_W-1:0] buf_size,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              pos_adv,
  output logic              err_null,
  output logic              err_bound
);
  localparam logic [DATA_W:0] WORD_BYTES = (DATA_W + 1)'(DATA_W / 8);

  logic            addr_null;
  logic [DATA_W:0] end_pos;
  logic            past_end;
  logic            go;

  assign addr_null = (buf_addr == '0);
  assign end_pos   = {1'b0, buf_pos} + WORD_BYTES;
  assign past_end  = end_pos > {1'b0, buf_size};
  assign go        = data_fire && !addr_null && !past_end;
  assign pos_adv   = go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      err_null  <= 1'b0;
      err_bound <= 1'b0;
    end else begin
      err_null  <= data_fire && addr_null;
      err_bound <= data_fire && !addr_null && past_end;
      if (go) begin
        mem_valid <= 1'b1;
        mem_addr  <= buf_addr + {{(ADDR_W-DATA_W){1'b0}}, buf_pos};
        mem_data  <= data_val;
      end else if (mem_ready) begin
        mem_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cbu_bind_table.sv
module cbu_bind_table
  import cbu_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tw_en,
  input  logic [STG_W-1:0]  tw_stage,
  input  logic [SLOT_W-1:0] tw_slot,
  input  bind_rec_t         tw_rec,
  input  logic [STG_W-1:0]  rd_stage,
  input  logic [SLOT_W-1:0] rd_slot,
  output bind_rec_t         rd_rec
);
  bind_rec_t tab [NUM_STAGES][NUM_SLOTS];
  logic      hit [NUM_STAGES][NUM_SLOTS];

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      assign hit[s][k] = tw_en && (tw_stage == STG_W'(s)) && (tw_slot == SLOT_W'(k));
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_STAGES; s++) begin
      for (int k = 0; k < NUM_SLOTS; k++) begin
        if (!rst_n)         tab[s][k] <= '0;
        else if (hit[s][k]) tab[s][k] <= tw_rec;
      end
    end
  end

  always_comb begin
    rd_rec = '0;
    for (int s = 0; s < NUM_STAGES; s++) begin
      for (int k = 0; k < NUM_SLOTS; k++) begin
        if (rd_stage == STG_W'(s) && rd_slot == SLOT_W'(k)) rd_rec = tab[s][k];
      end
    end
  end
endmodule

// File: rtl/cbu_upload_ctrl.sv
module cbu_upload_ctrl
  import cbu_pkg::*;
#(
  parameter int unsigned       IDX_W          = 8,
  parameter logic [IDX_W-1:0]  REG_ADDR_HI    = 8'h00,
  parameter logic [IDX_W-1:0]  REG_ADDR_LO    = 8'h01,
  parameter logic [IDX_W-1:0]  REG_SIZE       = 8'h02,
  parameter logic [IDX_W-1:0]  REG_POS        = 8'h03,
  parameter logic [IDX_W-1:0]  DATA_BASE      = 8'h10,
  parameter int unsigned       NUM_DATA_PORTS = 16,
  parameter logic [IDX_W-1:0]  BIND_BASE      = 8'h20,
  parameter int unsigned       NUM_SLOTS      = 18,
  parameter int unsigned       BIND_SLOT_LSB  = 4,
  parameter logic [31:0]       SETUP_SIZE     = 32'h0001_0000,
  parameter int unsigned       SETUP_SHIFT    = 8,
  parameter int unsigned       SETUP_SLOT     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              setup_stb,
  input  logic [STG_W-1:0]  setup_stage,
  input  logic [DATA_W-1:0] setup_param,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              busy,
  output logic              err_null,
  output logic              err_bound,
  input  logic [STG_W-1:0]  rd_stage,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              rd_en,
  output logic [SLOT_W-1:0] rd_index,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_size
);
  localparam logic [IDX_W-1:0]  DATA_SPAN = IDX_W'(NUM_DATA_PORTS);
  localparam logic [IDX_W-1:0]  BIND_SPAN = IDX_W'(NUM_STAGES);
  localparam logic [SLOT_W-1:0] SLOT_LIM  = SLOT_W'(NUM_SLOTS);
  localparam logic [SLOT_W-1:0] SETUP_SLOT_V = SLOT_W'(SETUP_SLOT);

  logic              wr_fire, data_fire, setup_fire, pos_adv;
  logic [IDX_W-1:0]  data_off, bind_off;
  logic              is_data, is_bind;
  logic [SLOT_W-1:0] bind_slot;
  logic [ADDR_W-1:0] setup_addr;
  logic [ADDR_W-1:0] buf_addr;
  logic [DATA_W-1:0] buf_size, buf_pos;
  logic              tw_en;
  logic [STG_W-1:0]  tw_stage;
  logic [SLOT_W-1:0] tw_slot;
  bind_rec_t         tw_rec, rd_rec;

  // Handshake: stalled while a request is pending or a preset is asked for
  assign wr_ready   = !mem_valid && !setup_stb;
  assign wr_fire    = wr_valid && wr_ready;
  assign busy       = mem_valid;
  assign setup_fire = setup_stb && !mem_valid && (setup_stage < STG_W'(NUM_STAGES));
  assign setup_addr = {{(ADDR_W-DATA_W){1'b0}}, setup_param} << SETUP_SHIFT;

  // Index decode for the aliased data ports and the stage bind registers
  assign data_off  = wr_idx - DATA_BASE;
  assign bind_off  = wr_idx - BIND_BASE;
  assign is_data   = (wr_idx >= DATA_BASE) && (data_off < DATA_SPAN);
  assign is_bind   = (wr_idx >= BIND_BASE) && (bind_off < BIND_SPAN);
  assign data_fire = wr_fire && is_data;
  assign bind_slot = wr_data[BIND_SLOT_LSB +: SLOT_W];

  always_comb begin
    tw_en    = 1'b0;
    tw_stage = '0;
    tw_slot  = '0;
    tw_rec   = '0;
    if (setup_fire) begin
      tw_en       = 1'b1;
      tw_stage    = setup_stage;
      tw_slot     = SETUP_SLOT_V;
      tw_rec.en   = 1'b1;
      tw_rec.idx  = SETUP_SLOT_V;
      tw_rec.addr = setup_addr;
      tw_rec.size = SETUP_SIZE;
    end else if (wr_fire && is_bind && bind_slot < SLOT_LIM) begin
      tw_en       = 1'b1;
      tw_stage    = bind_off[STG_W-1:0];
      tw_slot     = bind_slot;
      tw_rec.en   = wr_data[0];
      tw_rec.idx  = bind_slot;
      tw_rec.addr = buf_addr;
      tw_rec.size = buf_size;
    end
  end

  cbu_cfg_regs #(
    .IDX_W(IDX_W), .REG_ADDR_HI(REG_ADDR_HI), .REG_ADDR_LO(REG_ADDR_LO),
    .REG_SIZE(REG_SIZE), .REG_POS(REG_POS), .SETUP_SIZE(SETUP_SIZE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(wr_data),
    .pos_adv(pos_adv), .setup_fire(setup_fire), .setup_addr(setup_addr),
    .buf_addr(buf_addr), .buf_size(buf_size), .buf_pos(buf_pos)
  );

  cbu_data_path u_dp (
    .clk(clk), .rst_n(rst_n), .data_fire(data_fire), .data_val(wr_data),
    .buf_addr(buf_addr), .buf_pos(buf_pos), .buf_size(buf_size),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_data(mem_data), .pos_adv(pos_adv), .err_null(err_null), .err_bound(err_bound)
  );

  cbu_bind_table #(.NUM_SLOTS(NUM_SLOTS)) u_tab (
    .clk(clk), .rst_n(rst_n), .tw_en(tw_en), .tw_stage(tw_stage), .tw_slot(tw_slot),
    .tw_rec(tw_rec), .rd_stage(rd_stage), .rd_slot(rd_slot), .rd_rec(rd_rec)
  );

  assign rd_en    = rd_rec.en;
  assign rd_index = rd_rec.idx;
  assign rd_addr  = rd_rec.addr;
  assign rd_size  = rd_rec.size;
endmodule

// File: rtl/cbu_upload_ctrl_checker.sv
module cbu_upload_ctrl_checker #(
  parameter int unsigned      IDX_W          = 8,
  parameter logic [IDX_W-1:0] DATA_BASE      = 8'h10,
  parameter int unsigned      NUM_DATA_PORTS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [IDX_W-1:0] wr_idx,
  input logic             setup_stb,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [63:0]      mem_addr,
  input logic [31:0]      mem_data,
  input logic             busy,
  input logic             err_null,
  input logic             err_bound
);
  logic is_dp;
  assign is_dp = (wr_idx >= DATA_BASE) && ((wr_idx - DATA_BASE) < IDX_W'(NUM_DATA_PORTS));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !wr_ready && busy);

  assert_err_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_null && err_bound));

  assert_reject_no_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_null || err_bound) |-> !mem_valid);

  assert_issue_or_error_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && is_dp |=> mem_valid ^ (err_null || err_bound));

  assert_setup_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    setup_stb |-> !wr_ready);
endmodule

bind cbu_upload_ctrl cbu_upload_ctrl_checker #(
  .IDX_W(IDX_W), .DATA_BASE(DATA_BASE), .NUM_DATA_PORTS(NUM_DATA_PORTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx),
  .setup_stb(setup_stb), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy),
  .err_null(err_null), .err_bound(err_bound)
);

// File: tb/cbu_upload_ctrl_bench.sv
`timescale 1ns/1ps
module cbu_upload_ctrl_bench;
  localparam int NST = 5;
  localparam int NSL = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        setup_stb = 1'b0;
  logic [2:0]  setup_stage = '0;
  logic [31:0] setup_param = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [63:0] mem_addr;
  logic [31:0] mem_data;
  logic        busy, err_null, err_bound;
  logic [2:0]  rd_stage = '0;
  logic [4:0]  rd_slot = '0;
  logic        rd_en;
  logic [4:0]  rd_index;
  logic [63:0] rd_addr;
  logic [31:0] rd_size;

  always #4 clk = ~clk;

  cbu_upload_ctrl u_cbu_upload_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_idx(wr_idx), .wr_data(wr_data), .setup_stb(setup_stb),
    .setup_stage(setup_stage), .setup_param(setup_param), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy),
    .err_null(err_null), .err_bound(err_bound), .rd_stage(rd_stage),
    .rd_slot(rd_slot), .rd_en(rd_en), .rd_index(rd_index), .rd_addr(rd_addr),
    .rd_size(rd_size)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_hi, m_lo, m_size, m_pos;
  logic        t_en   [NST][NSL];
  logic [4:0]  t_idx  [NST][NSL];
  logic [63:0] t_addr [NST][NSL];
  logic [31:0] t_size [NST][NSL];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] base64();
    return {m_hi, m_lo};
  endfunction

  function automatic bit would_overflow(input logic [31:0] pos, input logic [31:0] size);
    return ({1'b0, pos} + 33'd4) > {1'b0, size};
  endfunction

  task automatic wr_reg(input logic [7:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = idx; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic set_cfg(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] sz, input logic [31:0] pos);
    wr_reg(8'h00, hi); m_hi = hi;
    wr_reg(8'h01, lo); m_lo = lo;
    wr_reg(8'h02, sz); m_size = sz;
    wr_reg(8'h03, pos); m_pos = pos;
  endtask

  task automatic data_write(input int port, input logic [31:0] v);
    logic [63:0] exp_addr;
    exp_addr = base64() + {32'd0, m_pos};
    wr_reg(8'h10 + 8'(port), v);
    if (base64() == 64'd0) begin
      check(err_null === 1'b1 && mem_valid === 1'b0 && err_bound === 1'b0, "R4 null base rejects",
            {62'd0, err_null, mem_valid}, 64'h2);
    end else if (would_overflow(m_pos, m_size)) begin
      check(err_bound === 1'b1 && mem_valid === 1'b0 && err_null === 1'b0, "R5 past end rejects",
            {62'd0, err_bound, mem_valid}, 64'h2);
    end else begin
      check(mem_valid === 1'b1 && err_null === 1'b0 && err_bound === 1'b0, "R2 request raised",
            {63'd0, mem_valid}, 64'd1);
      check(mem_addr === exp_addr, "R2 R3 request address", mem_addr, exp_addr);
      check(mem_data === v, "R2 request data", {32'd0, mem_data}, {32'd0, v});
      m_pos = m_pos + 32'd4;
      for (int i = 0; i < int'($urandom_range(0, 3)); i++) begin
        @(negedge clk);
        check(mem_valid === 1'b1 && mem_addr === exp_addr && mem_data === v && wr_ready === 1'b0 && busy === 1'b1,
              "R6 request held while not ready", mem_addr, exp_addr);
      end
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
      check(mem_valid === 1'b0 && busy === 1'b0, "R6 request retired after ready",
            {63'd0, mem_valid}, 64'd0);
    end
  endtask

  task automatic bind_write(input int stage, input logic [31:0] d);
    int slot;
    slot = int'(d[8:4]);
    wr_reg(8'h20 + 8'(stage), d);
    if (slot < NSL) begin
      t_en[stage][slot]   = d[0];
      t_idx[stage][slot]  = d[8:4];
      t_addr[stage][slot] = base64();
      t_size[stage][slot] = m_size;
    end
  endtask

  task automatic do_setup(input logic [2:0] stage, input logic [31:0] param);
    logic [63:0] a;
    @(negedge clk);
    setup_stb = 1'b1; setup_stage = stage; setup_param = param;
    #1;
    check(wr_ready === 1'b0, "R9 write port stalled during setup", {63'd0, wr_ready}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    setup_stb = 1'b0;
    if (stage < 3'd5) begin
      a = {32'd0, param} << 8;
      m_hi = a[63:32]; m_lo = a[31:0]; m_size = 32'h0001_0000;
      t_en[stage][1] = 1'b1; t_idx[stage][1] = 5'd1;
      t_addr[stage][1] = a; t_size[stage][1] = 32'h0001_0000;
    end
  endtask

  task automatic chk_slot(input int s, input int k, input string req);
    rd_stage = 3'(s); rd_slot = 5'(k);
    #1;
    check(rd_en === t_en[s][k] && rd_index === t_idx[s][k] && rd_addr === t_addr[s][k] && rd_size === t_size[s][k],
          req, rd_addr, t_addr[s][k]);
  endtask

  task automatic chk_all(input string req);
    for (int s = 0; s < NST; s++)
      for (int k = 0; k < NSL; k++)
        chk_slot(s, k, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_hi = 0; m_lo = 0; m_size = 0; m_pos = 0;
    for (int s = 0; s < NST; s++)
      for (int k = 0; k < NSL; k++) begin
        t_en[s][k] = 0; t_idx[s][k] = 0; t_addr[s][k] = 0; t_size[s][k] = 0;
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(mem_valid === 1'b0 && busy === 1'b0 && err_null === 1'b0 && err_bound === 1'b0,
          "R1 outputs after reset", {60'd0, mem_valid, busy, err_null, err_bound}, 64'd0);
    check(wr_ready === 1'b1, "R1 ready after reset", {63'd0, wr_ready}, 64'd1);
    chk_all("R1 table clear after reset");

    // R4 zero base
    data_write(0, 32'hDEAD_0001);
    // R2 R3 requests on consecutive words, R5 boundary
    set_cfg(32'h0000_0001, 32'h0000_1000, 32'd8, 32'd0);
    data_write(0, 32'hA5A5_0000);
    data_write(15, 32'hA5A5_000F);
    data_write(9, 32'hBAD0_0000);          // R5: 8+4 > 8
    wr_reg(8'h03, 32'd4); m_pos = 32'd4;   // R7 direct position write
    data_write(7, 32'h7777_7777);          // R5: 4+4 == 8 accepted
    // R4 takes precedence over R5
    set_cfg(32'd0, 32'd0, 32'd0, 32'd100);
    data_write(3, 32'h0);

    // R8 binds, ignored slot, R7 position kept across bind
    set_cfg(32'h0000_0002, 32'h0000_0040, 32'd64, 32'd8);
    bind_write(2, 32'h0000_0111);
    chk_slot(2, 17, "R8 bind stores snapshot");
    bind_write(0, 32'hFFFF_FE20);
    chk_slot(0, 2, "R8 bind disabled record");
    bind_write(4, 32'h0000_0121);          // slot 18 ignored
    chk_all("R8 out-of-range slot ignored");
    data_write(1, 32'h1111_2222);          // R7: position still 8

    // R9 setup preset
    do_setup(3'd4, 32'h0001_2345);
    chk_slot(4, 1, "R9 setup binds slot 1");
    data_write(2, 32'h3333_4444);          // base 0x1234500, R7 position kept
    do_setup(3'd6, 32'hFFFF_FFFF);          // ignored
    chk_all("R9 invalid stage ignored");
    data_write(5, 32'h5555_6666);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 5) begin
        data_write(int'($urandom_range(0, 15)), $urandom);
      end else if (op == 5) begin
        wr_reg(8'h03, 32'($urandom_range(0, 20)) * 32'd4); m_pos = rd_pos_shadow();
      end else if (op == 6) begin
        set_cfg(($urandom_range(0, 3) == 0) ? 32'd0 : $urandom,
                ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom,
                32'($urandom_range(0, 80)), 32'($urandom_range(0, 16)) * 32'd4);
      end else if (op < 9) begin
        bind_write(int'($urandom_range(0, 4)),
                   ($urandom & ~32'h0000_01F0) | (32'($urandom_range(0, 20)) << 4));
      end else begin
        do_setup(3'($urandom_range(0, 6)), $urandom);
      end
    end
    chk_all("R8 R9 table after random mix");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  function automatic logic [31:0] rd_pos_shadow();
    return wr_data;
  endfunction
endmodule